// File: doc/BRIEF.md
# Processor Register Bank with Packed Status Word

This block holds the architectural registers of a small 16-bit processor core. Six data registers (two of them also feed the arithmetic unit as operands), a program counter and a status word are kept in flip-flops. The arithmetic unit's result is not stored here: it can be read through the bank as a read-only register. One write port and two combinational read ports take a 4-bit register index, so an instruction sequencer can move data between registers and drive the operand and address paths in the same cycle.

The status word packs four sub-fields. An 8-bit IO select and a 4-bit operation select can each be loaded on their own through dedicated strobes. A single exchange bit flips on its own strobe and drives an output pin. The top three bits mirror the arithmetic unit's carry, zero and not-zero flags and cannot be written by software. The operand registers, the operation select, the IO select and the program counter also come out as dedicated outputs, for the datapath that surrounds the bank.

Top module: `regbank_top`

## Requirements
- R1: A synchronous active-high reset clears every stored register (indices 0-7) to zero and drives `swap_o` low.
- R2: Register indices are A=0, B=1, C=2, D=3, E=4, F=5, status=6, PC=7, ALU output=8. A write with `wr_en` high to an index in 0-5 or 7 stores the 16-bit `wr_data` at the rising edge, and either read port then returns it combinationally.
- R3: Index 8 reads `alu_res_i` combinationally. Writes to indices 8-15 change no register. Reads of indices 9-15 return zero.
- R4: `io_set` loads `io_val` into status bits 7:0 and leaves all other status bits as they were.
- R5: `alu_set` loads `alu_val` into status bits 11:8 and leaves all other status bits as they were.
- R6: `swap_tgl` inverts status bit 12, and `swap_o` always equals that bit.
- R7: At every clock edge, status bits 13, 14 and 15 take `flag_carry_i`, `flag_zero_i` and `flag_nz_i`. Writes to the status register do not affect them.
- R8: A write to index 6 through the write port updates status bits 12:0 from `wr_data[12:0]`.
- R9: In the same cycle as a write to index 6, any field strobe takes priority for its own field. The swap toggle inverts the bit's value from before the edge.
- R10: `opa_o`, `opb_o` and `pc_o` equal registers A, B and PC. `alusel_o` equals status bits 11:8 and `iosel_o` equals status bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 16 | Write data |
| rd0_idx | input | 4 | Read port 0 index |
| rd0_data | output | 16 | Read port 0 data |
| rd1_idx | input | 4 | Read port 1 index |
| rd1_data | output | 16 | Read port 1 data |
| io_set | input | 1 | Load IO select field strobe |
| io_val | input | 8 | New IO select value |
| alu_set | input | 1 | Load operation select field strobe |
| alu_val | input | 4 | New operation select value |
| swap_tgl | input | 1 | Invert exchange bit strobe |
| alu_res_i | input | 16 | Result from the arithmetic unit |
| flag_carry_i | input | 1 | Carry flag from the arithmetic unit |
| flag_zero_i | input | 1 | Zero flag from the arithmetic unit |
| flag_nz_i | input | 1 | Not-zero flag from the arithmetic unit |
| opa_o | output | 16 | Register A |
| opb_o | output | 16 | Register B |
| alusel_o | output | 4 | Operation select field |
| iosel_o | output | 8 | IO select field |
| swap_o | output | 1 | Exchange bit |
| pc_o | output | 16 | Program counter |

## Verification
Each writable register gets a value that differs from every other register's value. Both read ports are then swept, so an index decode that points to the wrong register or a write that lands in two places shows up as a mismatch. All-ones writes go to the status word and to the out-of-range indices. These tell a correct field mask apart from one that lets software reach the flag bits or stores data for a nonexistent register. Single strobes on an all-ones or mixed status word show whether a field update disturbs its neighbours. A final cycle carries a full write, an IO strobe and a swap toggle together, which separates the required priority from a write-wins ordering.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int DW        = 16;
  localparam int IW        = 4;
  localparam int NSLOT     = 8;
  localparam int IO_LO     = 0;
  localparam int IO_W      = 8;
  localparam int OP_LO     = 8;
  localparam int OP_W      = 4;
  localparam int XCH_BIT   = 12;
  localparam int CY_BIT    = 13;
  localparam int FLAG_W    = 3;
  localparam int SW_LO_W   = XCH_BIT + 1;

  localparam logic [IW-1:0] IX_A  = 4'd0;
  localparam logic [IW-1:0] IX_B  = 4'd1;
  localparam logic [IW-1:0] IX_SR = 4'd6;
  localparam logic [IW-1:0] IX_PC = 4'd7;
  localparam logic [IW-1:0] IX_AO = 4'd8;

  // Next status word: software part first, then field strobes, then flags.
  function automatic logic [DW-1:0] sr_merge(
    input logic [DW-1:0]     old,
    input logic              full_we,
    input logic [DW-1:0]     wdata,
    input logic              io_set,
    input logic [IO_W-1:0]   io_val,
    input logic              op_set,
    input logic [OP_W-1:0]   op_val,
    input logic              xch_tgl,
    input logic [FLAG_W-1:0] flags
  );
    logic [DW-1:0] n;
    n = old;
    if (full_we) n[SW_LO_W-1:0] = wdata[SW_LO_W-1:0];
    if (io_set)  n[IO_LO +: IO_W] = io_val;
    if (op_set)  n[OP_LO +: OP_W] = op_val;
    if (xch_tgl) n[XCH_BIT] = ~old[XCH_BIT];
    n[CY_BIT +: FLAG_W] = flags;
    return n;
  endfunction
endpackage

// File: rtl/regbank_slots.sv
module regbank_slots
  import regbank_pkg::*;
#(
  parameter int W    = DW,
  parameter int IDXW = IW,
  parameter int NS   = NSLOT,
  parameter int SKIP = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [IDXW-1:0]     widx,
  input  logic [W-1:0]        wdata,
  output logic [NS-1:0][W-1:0] slots_o
);
  for (genvar i = 0; i < NS; i++) begin : g_slot
    if (i == SKIP) begin : g_hole
      assign slots_o[i] = '0;
    end else begin : g_reg
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)                             q <= '0;
        else if (we && widx == IDXW'(i))     q <= wdata;
      end
      assign slots_o[i] = q;
    end
  end
endmodule

// File: rtl/regbank_status.sv
module regbank_status
  import regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              full_we,
  input  logic [DW-1:0]     wdata,
  input  logic              io_set,
  input  logic [IO_W-1:0]   io_val,
  input  logic              op_set,
  input  logic [OP_W-1:0]   op_val,
  input  logic              xch_tgl,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [DW-1:0]     sr_o
);
  always_ff @(posedge clk) begin
    if (rst) sr_o <= '0;
    else     sr_o <= sr_merge(sr_o, full_we, wdata, io_set, io_val,
                              op_set, op_val, xch_tgl, flags_i);
  end
endmodule

// File: rtl/regbank_rdmux.sv
module regbank_rdmux
  import regbank_pkg::*;
#(
  parameter int W    = DW,
  parameter int IDXW = IW,
  parameter int NS   = NSLOT
) (
  input  logic [IDXW-1:0]      idx,
  input  logic [NS-1:0][W-1:0] slots,
  input  logic [W-1:0]         sr,
  input  logic [W-1:0]         ao,
  output logic [W-1:0]         data
);
  localparam int SW = $clog2(NS);
  always_comb begin
    if (idx == IX_SR)              data = sr;
    else if (idx == IX_AO)         data = ao;
    else if (idx < IDXW'(NS))      data = slots[idx[SW-1:0]];
    else                           data = '0;
  end
endmodule

// File: rtl/regbank_top.sv
module regbank_top
  import regbank_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [DW-1:0]   wr_data,
  input  logic [IW-1:0]   rd0_idx,
  output logic [DW-1:0]   rd0_data,
  input  logic [IW-1:0]   rd1_idx,
  output logic [DW-1:0]   rd1_data,
  input  logic            io_set,
  input  logic [IO_W-1:0] io_val,
  input  logic            alu_set,
  input  logic [OP_W-1:0] alu_val,
  input  logic            swap_tgl,
  input  logic [DW-1:0]   alu_res_i,
  input  logic            flag_carry_i,
  input  logic            flag_zero_i,
  input  logic            flag_nz_i,
  output logic [DW-1:0]   opa_o,
  output logic [DW-1:0]   opb_o,
  output logic [OP_W-1:0] alusel_o,
  output logic [IO_W-1:0] iosel_o,
  output logic            swap_o,
  output logic [DW-1:0]   pc_o
);
  logic [NSLOT-1:0][DW-1:0] slots;
  logic [DW-1:0]            sr_q;
  logic                     sr_full_we;
  logic                     wr_dropped;
  logic [FLAG_W-1:0]        live_flags;

  // Named events for the checker
  assign sr_full_we = wr_en && (wr_idx == IX_SR);
  assign wr_dropped = wr_en && (wr_idx >= IX_AO);
  assign live_flags = {flag_nz_i, flag_zero_i, flag_carry_i};

  regbank_slots #(.W(DW), .IDXW(IW), .NS(NSLOT), .SKIP(int'(IX_SR))) u_slots (
    .clk(clk), .rst(rst), .we(wr_en), .widx(wr_idx), .wdata(wr_data),
    .slots_o(slots)
  );

  regbank_status u_status (
    .clk(clk), .rst(rst), .full_we(sr_full_we), .wdata(wr_data),
    .io_set(io_set), .io_val(io_val), .op_set(alu_set), .op_val(alu_val),
    .xch_tgl(swap_tgl), .flags_i(live_flags), .sr_o(sr_q)
  );

  regbank_rdmux #(.W(DW), .IDXW(IW), .NS(NSLOT)) u_rd0 (
    .idx(rd0_idx), .slots(slots), .sr(sr_q), .ao(alu_res_i), .data(rd0_data)
  );

  regbank_rdmux #(.W(DW), .IDXW(IW), .NS(NSLOT)) u_rd1 (
    .idx(rd1_idx), .slots(slots), .sr(sr_q), .ao(alu_res_i), .data(rd1_data)
  );

  assign opa_o    = slots[IX_A[2:0]];
  assign opb_o    = slots[IX_B[2:0]];
  assign pc_o     = slots[IX_PC[2:0]];
  assign alusel_o = sr_q[OP_LO +: OP_W];
  assign iosel_o  = sr_q[IO_LO +: IO_W];
  assign swap_o   = sr_q[XCH_BIT];
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk
  import regbank_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              io_set,
  input logic [IO_W-1:0]   io_val,
  input logic              alu_set,
  input logic [OP_W-1:0]   alu_val,
  input logic              swap_tgl,
  input logic              sr_full_we,
  input logic              wr_dropped,
  input logic [FLAG_W-1:0] live_flags,
  input logic [DW-1:0]     sr_q,
  input logic              swap_o,
  input logic [DW-1:0]     opa_o,
  input logic [DW-1:0]     opb_o,
  input logic [DW-1:0]     pc_o
);
  // R4
  io_field_chk: assert property (@(posedge clk) disable iff (rst)
    io_set |=> sr_q[IO_LO +: IO_W] == $past(io_val));

  // R5
  op_field_chk: assert property (@(posedge clk) disable iff (rst)
    alu_set |=> sr_q[OP_LO +: OP_W] == $past(alu_val));

  // R6
  swap_flip_chk: assert property (@(posedge clk) disable iff (rst)
    swap_tgl |=> swap_o != $past(swap_o));

  // R6
  swap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!swap_tgl && !sr_full_we) |=> $stable(swap_o));

  // R7
  flag_track_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> sr_q[CY_BIT +: FLAG_W] == $past(live_flags));

  // R3
  dropped_wr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_dropped |=> $stable(opa_o) && $stable(opb_o) && $stable(pc_o));

  // R4
  io_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!io_set && !sr_full_we) |=> $stable(sr_q[IO_LO +: IO_W]));
endmodule

bind regbank_top regbank_chk u_chk (
  .clk(clk), .rst(rst), .io_set(io_set), .io_val(io_val),
  .alu_set(alu_set), .alu_val(alu_val), .swap_tgl(swap_tgl),
  .sr_full_we(sr_full_we), .wr_dropped(wr_dropped), .live_flags(live_flags),
  .sr_q(sr_q), .swap_o(swap_o), .opa_o(opa_o), .opb_o(opb_o), .pc_o(pc_o)
);

// File: tb/regbank_top_tb.sv
module regbank_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [15:0] wr_data;
  logic [3:0]  rd0_idx, rd1_idx;
  logic [15:0] rd0_data, rd1_data;
  logic        io_set, alu_set, swap_tgl;
  logic [7:0]  io_val;
  logic [3:0]  alu_val;
  logic [15:0] alu_res_i;
  logic        flag_carry_i, flag_zero_i, flag_nz_i;
  logic [15:0] opa_o, opb_o, pc_o;
  logic [3:0]  alusel_o;
  logic [7:0]  iosel_o;
  logic        swap_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  typedef struct {
    int          port;
    logic [3:0]  idx;
    logic [15:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  event     sample_ev;

  logic [15:0] model [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  regbank_top u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd0_idx(rd0_idx), .rd0_data(rd0_data), .rd1_idx(rd1_idx), .rd1_data(rd1_data),
    .io_set(io_set), .io_val(io_val), .alu_set(alu_set), .alu_val(alu_val),
    .swap_tgl(swap_tgl), .alu_res_i(alu_res_i), .flag_carry_i(flag_carry_i),
    .flag_zero_i(flag_zero_i), .flag_nz_i(flag_nz_i), .opa_o(opa_o), .opb_o(opb_o),
    .alusel_o(alusel_o), .iosel_o(iosel_o), .swap_o(swap_o), .pc_o(pc_o)
  );

  // Monitor: pops expected reads and compares them with the port data
  initial begin
    forever begin
      @(sample_ev);
      while (sb_q.size() > 0) begin
        sb_item_t it;
        logic [15:0] got;
        it  = sb_q.pop_front();
        got = (it.port == 0) ? rd0_data : rd1_data;
        n_run++;
        if (got !== it.exp) begin
          n_fail++;
          $display("FAIL %s: port%0d idx %0d got %h expected %h",
                   it.tag, it.port, it.idx, got, it.exp);
        end
      end
    end
  end

  task automatic exp_rd(int port, logic [3:0] idx, logic [15:0] exp, string tag);
    sb_item_t it;
    if (port == 0) rd0_idx = idx; else rd1_idx = idx;
    it.port = port; it.idx = idx; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    #1;
    -> sample_ev;
    #1;
  endtask

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 0; io_set = 0; alu_set = 0; swap_tgl = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    idle_inputs();
  endtask

  task automatic wr(logic [3:0] idx, logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_idx = idx; wr_data = d;
    tick();
  endtask

  task automatic sweep(string tag);
    for (int i = 0; i < 8; i++) begin
      if (i != 6) begin
        exp_rd(0, 4'(i), model[i], tag);
        exp_rd(1, 4'(i), model[i], tag);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; idle_inputs(); wr_idx = 0; wr_data = 0; io_val = 0; alu_val = 0;
    rd0_idx = 0; rd1_idx = 0; alu_res_i = 16'h1234;
    flag_carry_i = 0; flag_zero_i = 0; flag_nz_i = 0;
    for (int i = 0; i < 8; i++) model[i] = 16'h0000;
    repeat (3) @(posedge clk);
    #1;
    // R1: all stored registers zero while reset is held
    sweep("R1");
    exp_rd(0, 4'd6, 16'h0000, "R1 status");
    chk("R1 swap_o", {15'b0, swap_o}, 16'h0000);
    // R3: ALU output alias reads the live input
    exp_rd(1, 4'd8, 16'h1234, "R3 alias");
    @(negedge clk); rst = 0;

    // R2: distinct values into every writable register
    for (int i = 0; i < 8; i++) begin
      if (i != 6) begin
        model[i] = 16'hA101 + 16'(i) * 16'h1111;
        wr(4'(i), model[i]);
      end
    end
    sweep("R2");
    // R10: dedicated outputs follow their registers
    chk("R10 opa_o", opa_o, model[0]);
    chk("R10 opb_o", opb_o, model[1]);
    chk("R10 pc_o",  pc_o,  model[7]);

    // R3: writes to indices 8..15 are dropped; high indices read zero
    for (int i = 8; i < 16; i++) wr(4'(i), 16'hFFFF);
    sweep("R3 dropped");
    exp_rd(0, 4'd9,  16'h0000, "R3 idx9");
    exp_rd(1, 4'd15, 16'h0000, "R3 idx15");
    alu_res_i = 16'hBEEF;
    exp_rd(0, 4'd8, 16'hBEEF, "R3 alias live");

    // R8/R7: full status write reaches bits 12:0 only
    wr(4'd6, 16'hFFFF);
    exp_rd(0, 4'd6, 16'h1FFF, "R8 full write");
    chk("R10 alusel_o", {12'b0, alusel_o}, 16'h000F);
    chk("R10 iosel_o",  {8'b0, iosel_o},   16'h00FF);
    chk("R6 swap_o after write", {15'b0, swap_o}, 16'h0001);

    // R4: IO field alone
    @(negedge clk); io_set = 1; io_val = 8'h5A; tick();
    exp_rd(1, 4'd6, 16'h1F5A, "R4 io field");
    // R5: operation select alone
    @(negedge clk); alu_set = 1; alu_val = 4'h3; tick();
    exp_rd(0, 4'd6, 16'h135A, "R5 op field");
    // R6: toggle twice
    @(negedge clk); swap_tgl = 1; tick();
    exp_rd(0, 4'd6, 16'h035A, "R6 toggle low");
    chk("R6 swap_o low", {15'b0, swap_o}, 16'h0000);
    @(negedge clk); swap_tgl = 1; tick();
    exp_rd(1, 4'd6, 16'h135A, "R6 toggle high");
    chk("R6 swap_o high", {15'b0, swap_o}, 16'h0001);

    // R7: flags arrive from the inputs (carry=bit13, zero=bit14, nz=bit15)
    @(negedge clk); flag_carry_i = 1; flag_zero_i = 0; flag_nz_i = 1; tick();
    exp_rd(0, 4'd6, 16'hB35A, "R7 flags in");
    wr(4'd6, 16'h0000);
    exp_rd(0, 4'd6, 16'hA000, "R7 write ignored by flags");
    @(negedge clk); flag_carry_i = 0; flag_zero_i = 1; flag_nz_i = 0; tick();
    exp_rd(1, 4'd6, 16'h4000, "R7 flags follow");

    // R9: full write + IO strobe + toggle in one cycle
    @(negedge clk);
    wr_en = 1; wr_idx = 4'd6; wr_data = 16'h0FFF;
    io_set = 1; io_val = 8'h11; swap_tgl = 1;
    tick();
    exp_rd(0, 4'd6, 16'h5F11, "R9 priority");
    chk("R9 swap_o", {15'b0, swap_o}, 16'h0001);
    sweep("R9 others intact");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule